// File: doc/BRIEF.md
# Circular Trace Capture Core

This block is the storage engine of an on-chip trace buffer. Trace words arrive as a valid/data stream and are written into a circular RAM at a write pointer that wraps modulo the RAM depth. A trigger input marks the point of interest. After the trigger has been seen, a post-trigger counter counts down once per stored word. When the counter is exhausted, acquisition completes and the RAM is frozen. Software therefore chooses how much history is kept after the trigger by loading the counter before capture starts, typically with depth × percent / 100.

A debug access port drives a simple register bus to control the core and drain it. The register map is: 0 control, 1 status, 2 post-trigger counter, 3 read pointer, 4 write pointer, 5 RAM data, 6 depth, 7 word width. To read out the buffer, software first checks the wrap flag. After a wrap, the oldest entry is at the write pointer. Without a wrap, the valid entries run from 0 to write pointer − 1. Software loads the read pointer accordingly and then reads the data register repeatedly.

Top module: `trace_capture_core`

## Requirements
- R1: After reset: control reads 0; the read pointer, the write pointer and the post-trigger counter read 0; status bits 0 to 2 read 0.
- R2: Register 6 returns DEPTH and register 7 returns WIDTH. Writes to either register have no effect.
- R3: Storing requires control bit 0 = 1 and status bit 2 = 0. In that state, each valid trace word is written at the write pointer, and the write pointer then advances by one modulo DEPTH. While control bit 0 = 0, no word is stored and the write pointer holds.
- R4: Status bit 0 (wrapped) sets when a word is stored at address DEPTH−1. It stays set until the write pointer is written.
- R5: Status bit 1 (triggered) sets when the trigger input is high while capture is enabled and bit 2 is clear. A trigger arriving while capture is disabled is ignored.
- R6: Once bit 1 is set, every stored word decrements the counter. A word presented together with the trigger is not counted. When the counter is 0 and bit 1 is set under enabled capture, status bit 2 (acquisition complete) sets on the next edge. From then on no further word is stored. A counter of N therefore keeps exactly N words after the trigger word.
- R7: Status bit 3 (drained) reads 1 exactly when capture was halted on each of the two previous clock edges. Halted means control bit 0 = 0 or bit 2 = 1.
- R8: Writing the write pointer loads it and clears status bits 0, 1 and 2 in the same edge.
- R9: A read of register 5 returns the RAM entry at the read pointer and advances the read pointer by one modulo DEPTH. Writing register 3 loads the read pointer.
- R10: Control bit 1 (demultiplexed port mode) is stored and read back. Control bits above bit 1 are ignored and read 0.
- R11: `reg_rdata` is loaded at the edge where `reg_rd` is sampled high, with the register value from before that edge. It holds at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tr_valid | input | 1 | Trace word valid |
| tr_data | input | WIDTH | Trace word |
| tr_trig | input | 1 | Trigger flag |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the core with DEPTH = 16 and WIDTH = 24. With that depth, a run of twenty words wraps the pointer and sets the wrapped flag, and a full oldest-first readout of sixteen entries also wraps the read pointer. The 24-bit width means the width register and the zero-extended data reads carry a value other than the bus width. A short post-trigger count of four and a count of zero reach the completion edge within a few words, including the case where completion follows the trigger word immediately.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_TCNT  = 3'd2,
    RA_RPTR  = 3'd3,
    RA_WPTR  = 3'd4,
    RA_DATA  = 3'd5,
    RA_DEPTH = 3'd6,
    RA_WIDTH = 3'd7
  } reg_addr_e;

  // bit order is decoded by software: [0] wrapped .. [3] drained
  typedef struct packed {
    logic dfempty;
    logic acq_done;
    logic trig_seen;
    logic wrapped;
  } stat_t;

endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/trc_acq.sv
module trc_acq
  import trc_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          cap_en,
  input  logic          tr_valid,
  input  logic          tr_trig,
  input  logic          wptr_we,
  input  logic          tcnt_we,
  input  logic [PW-1:0] wptr_wdata,
  input  logic [CW-1:0] tcnt_wdata,
  output logic          store_en,
  output logic          halted,
  output logic [PW-1:0] wptr,
  output logic [CW-1:0] tcnt,
  output stat_t         stat
);

  logic [PW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  stat_t         stat_q, stat_d;
  logic          s1_q, s1_d;
  logic          cnt_zero;

  always_comb begin
    halted   = ~cap_en | stat_q.acq_done;
    cnt_zero = (tcnt_q == '0);
    store_en = cap_en & ~stat_q.acq_done & tr_valid & ~(stat_q.trig_seen & cnt_zero);

    wptr_d = wptr_q;
    tcnt_d = tcnt_q;
    stat_d = stat_q;
    s1_d   = halted;
    stat_d.dfempty = s1_q & halted;

    if (cap_en & ~stat_q.acq_done & tr_trig) stat_d.trig_seen = 1'b1;
    if (cap_en & stat_q.trig_seen & cnt_zero) stat_d.acq_done = 1'b1;

    if (store_en) begin
      wptr_d = wptr_q + 1'b1;
      if (wptr_q == PW'(DEPTH - 1)) stat_d.wrapped = 1'b1;
      if (stat_q.trig_seen) tcnt_d = tcnt_q - 1'b1;
    end

    if (tcnt_we) tcnt_d = tcnt_wdata;

    if (wptr_we) begin
      wptr_d           = wptr_wdata;
      stat_d.wrapped   = 1'b0;
      stat_d.trig_seen = 1'b0;
      stat_d.acq_done  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wptr_q <= '0;
      tcnt_q <= '0;
      stat_q <= '0;
      s1_q   <= 1'b0;
    end else begin
      if (store_en | wptr_we) wptr_q <= wptr_d;
      if (store_en | tcnt_we) tcnt_q <= tcnt_d;
      stat_q <= stat_d;
      s1_q   <= s1_d;
    end
  end

  assign wptr = wptr_q;
  assign tcnt = tcnt_q;
  assign stat = stat_q;

endmodule

// File: rtl/trc_regif.sv
module trc_regif
  import trc_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  input  stat_t            stat,
  input  logic [PW-1:0]    wptr,
  input  logic [CW-1:0]    tcnt,
  input  logic [WIDTH-1:0] ram_rdata,
  output logic             cap_en,
  output logic             wptr_we,
  output logic             tcnt_we,
  output logic [PW-1:0]    rptr,
  output logic [31:0]      reg_rdata
);

  reg_addr_e     addr;
  logic          en_q, dm_q, en_d, dm_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [31:0]   rdata_q, rdata_d, rd_mux;
  logic          ctrl_we, rptr_we, data_rd;
  logic          wdata_unused;

  assign wdata_unused = ^reg_wdata;

  always_comb begin
    addr    = reg_addr_e'(reg_addr);
    ctrl_we = reg_wr & (addr == RA_CTRL);
    rptr_we = reg_wr & (addr == RA_RPTR);
    wptr_we = reg_wr & (addr == RA_WPTR);
    tcnt_we = reg_wr & (addr == RA_TCNT);
    data_rd = reg_rd & (addr == RA_DATA);

    case (addr)
      RA_CTRL:  rd_mux = {30'b0, dm_q, en_q};
      RA_STAT:  rd_mux = {28'b0, stat};
      RA_TCNT:  rd_mux = 32'(tcnt);
      RA_RPTR:  rd_mux = 32'(rptr_q);
      RA_WPTR:  rd_mux = 32'(wptr);
      RA_DATA:  rd_mux = 32'(ram_rdata);
      RA_DEPTH: rd_mux = 32'(DEPTH);
      default:  rd_mux = 32'(WIDTH);
    endcase

    en_d    = ctrl_we ? reg_wdata[0] : en_q;
    dm_d    = ctrl_we ? reg_wdata[1] : dm_q;
    rdata_d = reg_rd ? rd_mux : rdata_q;
    rptr_d  = rptr_q;
    if (rptr_we)      rptr_d = reg_wdata[PW-1:0];
    else if (data_rd) rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q    <= 1'b0;
      dm_q    <= 1'b0;
      rptr_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (ctrl_we)           {dm_q, en_q} <= {dm_d, en_d};
      if (rptr_we | data_rd) rptr_q <= rptr_d;
      if (reg_rd)            rdata_q <= rdata_d;
    end
  end

  assign cap_en    = en_q;
  assign rptr      = rptr_q;
  assign reg_rdata = rdata_q;

endmodule

// File: rtl/trace_capture_core.sv
module trace_capture_core
  import trc_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tr_valid,
  input  logic [WIDTH-1:0] tr_data,
  input  logic             tr_trig,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);

  logic [1:0]       rst_sync;
  logic             rst_ns;
  logic             cap_en, store_en, halted, wptr_we, tcnt_we;
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    tcnt;
  logic [WIDTH-1:0] ram_rdata;
  stat_t            stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  trc_acq #(.DEPTH(DEPTH)) u_acq (
    .clk(clk), .rst_ns(rst_ns), .cap_en(cap_en), .tr_valid(tr_valid), .tr_trig(tr_trig),
    .wptr_we(wptr_we), .tcnt_we(tcnt_we),
    .wptr_wdata(reg_wdata[PW-1:0]), .tcnt_wdata(reg_wdata[CW-1:0]),
    .store_en(store_en), .halted(halted), .wptr(wptr), .tcnt(tcnt), .stat(stat)
  );

  trc_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk(clk), .we(store_en), .waddr(wptr), .wdata(tr_data),
    .raddr(rptr), .rdata(ram_rdata)
  );

  trc_regif #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_regif (
    .clk(clk), .rst_ns(rst_ns), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .stat(stat), .wptr(wptr), .tcnt(tcnt), .ram_rdata(ram_rdata),
    .cap_en(cap_en), .wptr_we(wptr_we), .tcnt_we(tcnt_we), .rptr(rptr), .reg_rdata(reg_rdata)
  );

endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk
  import trc_pkg::*;
#(
  parameter int PW = 11,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          store_en,
  input logic          halted,
  input logic          wptr_we,
  input logic          tcnt_we,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [CW-1:0] tcnt,
  input stat_t         stat
);

  p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    !wptr_we |=> wptr == PW'($past(wptr) + PW'($past(store_en))));

  p_wrap_sticky_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    stat.wrapped && !wptr_we |=> stat.wrapped);

  p_no_store_done_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    stat.acq_done |-> !store_en);

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    stat.acq_done && !wptr_we |=> stat.acq_done);

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    !tcnt_we && !store_en |=> $stable(tcnt));

  p_drained_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    stat.dfempty |-> $past(halted));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    wptr_we |=> !stat.wrapped && !stat.trig_seen && !stat.acq_done);

  p_rptr_step_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    reg_rd && !reg_wr && reg_addr == 3'd5 |=> rptr == PW'($past(rptr) + 1'b1));

endmodule

bind trace_capture_core trc_capture_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .store_en(store_en), .halted(halted),
  .wptr_we(wptr_we), .tcnt_we(tcnt_we), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wptr(wptr), .rptr(rptr), .tcnt(tcnt), .stat(stat)
);

// File: tb/trace_capture_core_bench.sv
`timescale 1ns/1ps
module trace_capture_core_bench;

  localparam int D = 16;
  localparam int W = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tr_valid = 1'b0;
  logic [W-1:0]  tr_data = '0;
  logic          tr_trig = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  trace_capture_core #(.DEPTH(D), .WIDTH(W)) u_trace_capture_core (
    .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_data(tr_data), .tr_trig(tr_trig),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // behavioural reference model
  int  m_mem [D];
  int  m_wptr, m_rptr, m_cnt, m_rd;
  bit  m_en, m_dm, m_full, m_trg, m_acq, m_h1, m_df;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wptr = 0; m_rptr = 0; m_cnt = 0; m_rd = 0;
      m_en = 0; m_dm = 0; m_full = 0; m_trg = 0; m_acq = 0; m_h1 = 1; m_df = 1;
    end else begin
      bit halted, czero, store, n_acq, n_trg;
      halted = !m_en || m_acq;
      czero  = (m_cnt == 0);
      store  = m_en && !m_acq && tr_valid && !(m_trg && czero);
      if (reg_rd) begin
        case (reg_addr)
          3'd0: m_rd = {m_dm, m_en};
          3'd1: m_rd = {m_df, m_acq, m_trg, m_full};
          3'd2: m_rd = m_cnt;
          3'd3: m_rd = m_rptr;
          3'd4: m_rd = m_wptr;
          3'd5: m_rd = m_mem[m_rptr];
          3'd6: m_rd = D;
          default: m_rd = W;
        endcase
        if (reg_addr == 3'd5 && !(reg_wr && reg_addr == 3'd3)) m_rptr = (m_rptr + 1) % D;
      end
      n_acq = m_acq || (m_en && m_trg && czero);
      n_trg = m_trg || (m_en && !m_acq && tr_trig);
      if (store) begin
        m_mem[m_wptr] = int'(tr_data);
        if (m_wptr == D - 1) m_full = 1;
        m_wptr = (m_wptr + 1) % D;
        if (m_trg) m_cnt = m_cnt - 1;
      end
      m_df  = m_h1 && halted;
      m_h1  = halted;
      m_acq = n_acq;
      m_trg = n_trg;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin m_en = reg_wdata[0]; m_dm = reg_wdata[1]; end
          3'd2: m_cnt = int'(reg_wdata[4:0]);
          3'd3: m_rptr = int'(reg_wdata[3:0]);
          3'd4: begin m_wptr = int'(reg_wdata[3:0]); m_full = 0; m_trg = 0; m_acq = 0; end
          default: ;
        endcase
      end
    end
  end

  // R11: read data compared against the model on every clock
  always @(negedge clk) begin
    compared++;
    if (reg_rdata !== 32'(m_rd)) begin
      mismatched++;
      $display("FAIL R11 rdata stream: actual %h expected %h at %0t", reg_rdata, 32'(m_rd), $time);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic push(input logic [W-1:0] d, input logic t);
    @(negedge clk); tr_valid = 1'b1; tr_data = d; tr_trig = t;
    @(negedge clk); tr_valid = 1'b0; tr_trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(4); rst_n = 1'b1; idle(8);
    // R1 reset state
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd1, 32'h8, "R1 status");
    rd(3'd2, 32'h0, "R1 counter");
    rd(3'd3, 32'h0, "R1 rptr");
    rd(3'd4, 32'h0, "R1 wptr");
    // R2 geometry, writes ignored
    wr(3'd6, 32'h0); wr(3'd7, 32'h5);
    rd(3'd6, D, "R2 depth");
    rd(3'd7, W, "R2 width");
    // R10 demux bit only
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, 32'h2, "R10 ctrl readback");
    // R3/R5 disabled: words and trigger ignored
    push(24'h1111, 1'b1); push(24'h2222, 1'b0);
    rd(3'd4, 32'h0, "R3 wptr while disabled");
    idle(3);
    rd(3'd1, 32'h8, "R5 trigger ignored when disabled");
    // R6 post-trigger count of 4
    wr(3'd4, 0); wr(3'd2, 4); wr(3'd0, 1);
    for (int k = 0; k < 5; k++) push(W'(24'hA000 + k), 1'b0);
    rd(3'd4, 32'd5, "R3 wptr after 5 words");
    push(24'hA005, 1'b1);
    rd(3'd1, 32'h2, "R5 triggered");
    for (int k = 6; k < 15; k++) push(W'(24'hA000 + k), 1'b0);
    idle(3);
    rd(3'd4, 32'd10, "R6 words kept after trigger");
    rd(3'd2, 32'd0, "R6 counter exhausted");
    rd(3'd1, 32'hE, "R6 R7 done and drained");
    // R9 readout without wrap
    wr(3'd3, 0);
    for (int k = 0; k < 10; k++) rd(3'd5, 32'(24'hA000 + k), "R9 linear readout");
    rd(3'd3, 32'd10, "R9 rptr advanced");
    // R8 clear, then R4 wrap
    wr(3'd4, 0);
    idle(2);
    rd(3'd1, 32'h0, "R8 flags cleared");
    wr(3'd2, 20);
    for (int k = 0; k < 20; k++) push(W'(24'hB000 + k), 1'b0);
    rd(3'd4, 32'd4, "R3 wptr wrapped modulo depth");
    rd(3'd1, 32'h1, "R4 wrapped flag");
    wr(3'd3, 4);
    for (int k = 4; k < 20; k++) rd(3'd5, 32'(24'hB000 + k), "R9 oldest-first readout");
    rd(3'd3, 32'd4, "R9 rptr wrapped");
    // R7 disable drains
    wr(3'd0, 0); idle(3);
    rd(3'd1, 32'h9, "R7 drained after disable");
    push(24'hDEAD, 1'b0);
    rd(3'd4, 32'd4, "R3 no store after disable");
    // R6 counter zero: only the trigger word kept
    wr(3'd4, 0); wr(3'd2, 0); wr(3'd0, 1);
    push(24'hC000, 1'b1); push(24'hC001, 1'b0); idle(3);
    rd(3'd4, 32'd1, "R6 zero count keeps trigger word only");
    rd(3'd1, 32'hE, "R6 done with zero count");
    wr(3'd3, 0);
    rd(3'd5, 32'h00C000, "R9 trigger word stored");
    idle(2);
    summary();
  end

endmodule